// File: doc/BRIEF.md
# ADC Conversion Sequencer and Trigger Controller

This block is the digital control for an eight-channel successive-approximation converter. It latches a packed configuration word and uses it to decide when a conversion begins, which analog channel the converter samples, and for how many clock cycles the conversion runs. While a conversion is under way it drives a channel index and an active strobe to the converter. On the final active cycle it captures the converter's output word into that channel's result register.

Conversions can start in three ways. A single conversion can be launched once on each configuration write. A conversion can be launched by a chosen edge of one of five external trigger lines, which are synchronized on the way in. In burst mode the block scans repeatedly through every enabled channel in ascending order. A 3-bit speed selector trades conversion length against resolution. Each channel's result register carries a done flag and an overrun flag, and both are cleared by reading that channel.

Top module: `adc_seq_top`

## Requirements
- R1: `ctrlWord` is latched on the edge where `ctrlWr` is 1 and governs starts from the next cycle. Its layout is: bit 0 trigger polarity (0 rising, 1 falling), bits 3:1 start mode, bit 4 power-on, bit 5 burst, bits 8:6 speed selector n, bits 16:9 channel mask. After reset `convActive` is 0 and no channel reports done.
- R2: While the power-on bit is 0, no conversion starts in any mode.
- R3: With start mode 1 and burst 0, exactly one conversion runs, on the lowest-numbered channel whose mask bit is 1, starting on the edge after the write is latched. No further conversion starts until `ctrlWr` is pulsed again. An all-zero mask starts nothing in any mode.
- R4: A conversion keeps `convActive` high for 11−n consecutive cycles. The stored result is `convData` sampled in the last active cycle and shifted right by n, so that its 10−n bits sit in the least-significant positions.
- R5: With burst 1, start mode 0 and power-on 1, conversions repeat with one idle cycle between them. They visit the selected channels in ascending order and wrap back to the lowest. Every scan that starts after burst was off begins at the lowest selected channel.
- R6: With burst 1 and a start mode other than 0, no conversion starts.
- R7: Clearing the burst bit during a conversion lets that conversion run its full length, and no later conversion starts.
- R8: Start modes 2 to 6 select trigger input `extTrig[mode−2]`, qualified by the polarity bit. A qualifying edge starts a conversion on the lowest selected channel: `convActive` rises on the third rising clock edge after the input changes. Edges on the other trigger inputs start nothing.
- R9: Trigger edges that arrive while a conversion is active are discarded. Start mode 0 and start mode 7 never start a conversion outside burst.
- R10: Each channel has its own result register. A capture sets the done flag. Reading the channel (`rdEn`) returns the register and clears done and overrun. A capture into a channel whose done flag is still set, with no read on that edge, sets its overrun flag.
- R11: The channel index and the length of a conversion are fixed when it starts. Configuration writes during a conversion do not alter either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Latch `ctrlWord` this cycle |
| ctrlWord | input | 17 | Packed configuration word (layout in R1) |
| extTrig | input | 5 | Asynchronous external trigger lines |
| convData | input | 10 | Result from the converter, valid in the last active cycle |
| rdEn | input | 1 | Read strobe; clears the flags of `rdChan` |
| rdChan | input | 3 | Channel to read |
| convActive | output | 1 | Conversion in progress |
| convChan | output | 3 | Channel being converted |
| rdData | output | 10 | Result register of `rdChan` |
| rdDone | output | 1 | Done flag of `rdChan` |
| rdOverrun | output | 1 | Overrun flag of `rdChan` |

## Verification
A configuration write is latched on the edge that sees `ctrlWr`. An immediate start raises `convActive` one edge later. A trigger edge raises it on the third edge after the input changes. A result and its done flag become visible on the edge that ends the last active cycle, and the read data path is combinational. The bench drives inputs on falling edges. It checks trigger latency 1 ns after the named rising edges, and it judges lengths, channel order and completion from a falling-edge monitor that logs every finished conversion. This keeps each comparison clear of the clock edge where the value changes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 8;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int RES_W = 10;
  localparam int SEL_W = 3;
  localparam int MODE_W = 3;

  // packed word: first field is the most significant
  typedef struct packed {
    logic [NUM_CH-1:0] mask;
    logic [SEL_W-1:0]  clkSel;
    logic              burst;
    logic              powerOn;
    logic [MODE_W-1:0] startMode;
    logic              trigFalling;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // control-to-datapath strobes
  typedef struct packed {
    logic             capture;
    logic [CH_W-1:0]  chan;
    logic [SEL_W-1:0] shift;
  } capStrobe_t;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int NUM_TRIG = 5,
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                fallSel,
  output logic [NUM_TRIG-1:0] trigEdge
);
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic [STAGES:0] pipe;
    logic synced, prevSynced;

    always_ff @(posedge clk) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[STAGES-1:0], trigIn[i]};
    end

    assign synced = pipe[STAGES-1];
    assign prevSynced = pipe[STAGES];
    assign trigEdge[i] = fallSel ? (prevSynced & ~synced) : (synced & ~prevSynced);
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_TRIG = 5,
  parameter int FULL_CLKS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  cfg_t                cfgIn,
  input  logic [NUM_TRIG-1:0] trigEdge,
  output logic                trigFallSel,
  output logic                convActive,
  output logic [CH_W-1:0]     convChan,
  output capStrobe_t          cap
);
  localparam int CNT_W = $clog2(FULL_CLKS);

  cfg_t             cfgQ;
  logic             armed, busy, scanLive;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  chanQ, lastChan;
  logic [SEL_W-1:0] shiftQ;

  logic [CH_W-1:0]  lowest, nextUp, startChan;
  logic             haveUp, anySel, trigHit;
  logic             burstGo, immGo, trigGo, startNow;
  logic [CNT_W-1:0] lenM1;

  // lowest selected channel, and lowest selected channel above the last one
  always_comb begin
    lowest = '0;
    nextUp = '0;
    haveUp = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cfgQ.mask[i]) lowest = CH_W'(i);
      if (cfgQ.mask[i] && (i > int'(lastChan))) begin
        nextUp = CH_W'(i);
        haveUp = 1'b1;
      end
    end
  end

  // trigger input selected by the start mode (modes 2 upward)
  always_comb begin
    trigHit = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++)
      if (cfgQ.startMode == MODE_W'(i + 2)) trigHit = trigEdge[i];
  end

  assign anySel  = |cfgQ.mask;
  assign burstGo = cfgQ.powerOn & cfgQ.burst & (cfgQ.startMode == '0) & anySel;
  assign immGo   = cfgQ.powerOn & ~cfgQ.burst & (cfgQ.startMode == MODE_W'(1)) & armed & anySel;
  assign trigGo  = cfgQ.powerOn & ~cfgQ.burst & trigHit & anySel;
  assign startNow = ~busy & (burstGo | immGo | trigGo);
  assign startChan = (burstGo && scanLive && haveUp) ? nextUp : lowest;
  assign lenM1 = CNT_W'(FULL_CLKS - 1) - CNT_W'(cfgQ.clkSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ     <= '0;
      armed    <= 1'b0;
      scanLive <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      chanQ    <= '0;
      shiftQ   <= '0;
      lastChan <= '0;
    end else begin
      if (ctrlWr) cfgQ <= cfgIn;
      if (ctrlWr) armed <= 1'b1;
      else if (startNow && immGo) armed <= 1'b0;
      if (!cfgQ.burst) scanLive <= 1'b0;
      else if (startNow && burstGo) scanLive <= 1'b1;
      if (startNow) begin
        busy   <= 1'b1;
        cnt    <= lenM1;
        chanQ  <= startChan;
        shiftQ <= cfgQ.clkSel;
        if (burstGo) lastChan <= startChan;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  assign convActive  = busy;
  assign convChan    = chanQ;
  assign trigFallSel = cfgQ.trigFalling;
  assign cap.capture = busy & (cnt == '0);
  assign cap.chan    = chanQ;
  assign cap.shift   = shiftQ;

  // checking state
  logic [CNT_W:0]    runCnt;
  logic [NUM_CH-1:0] maskPrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt   <= '0;
      maskPrev <= '0;
    end else begin
      runCnt   <= busy ? runCnt + 1'b1 : '0;
      maskPrev <= cfgQ.mask;
    end
  end

  p_no_start_pdown_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgQ.powerOn) |=> !busy);
  p_imm_once_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !armed && !cfgQ.burst && cfgQ.startMode == MODE_W'(1)) |=> !busy);
  p_start_on_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> maskPrev[chanQ]);
  p_conv_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> int'(runCnt) == FULL_CLKS - int'(shiftQ));
  p_burst_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfgQ.burst && cfgQ.startMode != '0) |=> !busy);
  p_chan_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cap.capture) |=> (busy && $stable(convChan)));
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       cap,
  input  logic [RES_W-1:0] convData,
  input  logic             rdEn,
  input  logic [CH_W-1:0]  rdChan,
  output logic [RES_W-1:0] rdData,
  output logic             rdDone,
  output logic             rdOverrun
);
  logic [RES_W-1:0]  resVec [NUM_CH];
  logic [NUM_CH-1:0] doneVec, ovrVec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hitCap, hitRd;
    assign hitCap = cap.capture && (cap.chan == CH_W'(i));
    assign hitRd  = rdEn && (rdChan == CH_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resVec[i]  <= '0;
        doneVec[i] <= 1'b0;
        ovrVec[i]  <= 1'b0;
      end else if (hitCap) begin
        resVec[i]  <= convData >> cap.shift;
        doneVec[i] <= 1'b1;
        ovrVec[i]  <= hitRd ? 1'b0 : (ovrVec[i] | doneVec[i]);
      end else if (hitRd) begin
        doneVec[i] <= 1'b0;
        ovrVec[i]  <= 1'b0;
      end
    end
  end

  assign rdData    = resVec[rdChan];
  assign rdDone    = doneVec[rdChan];
  assign rdOverrun = ovrVec[rdChan];

  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cap.capture && doneVec[cap.chan] && !(rdEn && rdChan == cap.chan))
      |=> ovrVec[$past(cap.chan)]);
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !(cap.capture && cap.chan == rdChan))
      |=> (!doneVec[$past(rdChan)] && !ovrVec[$past(rdChan)]));
  p_done_from_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cap.capture) |=> doneVec[$past(cap.chan)]);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_TRIG = 5,
  parameter int SYNC_STAGES = 2,
  parameter int FULL_CLKS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic [CFG_W-1:0]    ctrlWord,
  input  logic [NUM_TRIG-1:0] extTrig,
  input  logic [RES_W-1:0]    convData,
  input  logic                rdEn,
  input  logic [CH_W-1:0]     rdChan,
  output logic                convActive,
  output logic [CH_W-1:0]     convChan,
  output logic [RES_W-1:0]    rdData,
  output logic                rdDone,
  output logic                rdOverrun
);
  logic [NUM_TRIG-1:0] trigEdge;
  logic                fallSel;
  capStrobe_t          cap;

  adc_trig_edge #(.NUM_TRIG(NUM_TRIG), .STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rstN(rstN), .trigIn(extTrig), .fallSel(fallSel), .trigEdge(trigEdge)
  );

  adc_seq_ctrl #(.NUM_TRIG(NUM_TRIG), .FULL_CLKS(FULL_CLKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .cfgIn(cfg_t'(ctrlWord)),
    .trigEdge(trigEdge), .trigFallSel(fallSel), .convActive(convActive),
    .convChan(convChan), .cap(cap)
  );

  adc_seq_result i_result (
    .clk(clk), .rstN(rstN), .cap(cap), .convData(convData), .rdEn(rdEn),
    .rdChan(rdChan), .rdData(rdData), .rdDone(rdDone), .rdOverrun(rdOverrun)
  );
endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0;
  logic [16:0] ctrlWord = '0;
  logic [4:0] extTrig = '0;
  logic [9:0] convData;
  logic rdEn = 1'b0;
  logic [2:0] rdChan = '0;
  logic convActive, rdDone, rdOverrun;
  logic [2:0] convChan;
  logic [9:0] rdData;

  logic [9:0] chanVal [8];
  int testsRun = 0, testsFailed = 0;
  int logChan [256];
  int logLen [256];
  int logCount = 0;
  int runLen = 0, curChan = 0;
  bit wasActive = 0;

  always #5 clk = ~clk;
  assign convData = chanVal[convChan];

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWord(ctrlWord), .extTrig(extTrig),
    .convData(convData), .rdEn(rdEn), .rdChan(rdChan), .convActive(convActive),
    .convChan(convChan), .rdData(rdData), .rdDone(rdDone), .rdOverrun(rdOverrun)
  );

  // log every finished conversion (channel, length)
  always @(negedge clk) begin
    if (rstN) begin
      if (convActive) begin
        if (!wasActive) begin curChan = int'(convChan); runLen = 1; end
        else runLen++;
      end else if (wasActive && logCount < 256) begin
        logChan[logCount] = curChan;
        logLen[logCount] = runLen;
        logCount++;
      end
      wasActive = convActive;
    end
  end

  function automatic logic [16:0] mkCfg(int mask, int sel, int burst, int pwr, int mode, int fall);
    return {mask[7:0], sel[2:0], burst[0], pwr[0], mode[2:0], fall[0]};
  endfunction

  function automatic int lowestBit(int mask);
    for (int i = 0; i < 8; i++) if (mask[i]) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(logic [16:0] w);
    @(negedge clk);
    ctrlWord = w;
    ctrlWr = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic readCh(int ch, output int d, output int dn, output int ov);
    @(negedge clk);
    rdChan = 3'(ch);
    rdEn = 1'b1;
    #1;
    d = int'(rdData); dn = int'(rdDone); ov = int'(rdOverrun);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic randVals();
    for (int i = 0; i < 8; i++) chanVal[i] = 10'($urandom);
  endtask

  task automatic waitCount(int target);
    for (int i = 0; i < 2000 && logCount < target; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int d, dn, ov, base, mask, sel, k, ch, mode, fall, idx, other;
    int list [8];
    void'($urandom(32'd4021));
    randVals();
    waitCycles(3);
    rstN = 1'b1;

    // R1 reset state
    #1 check(convActive == 1'b0, "R1 reset active", int'(convActive), 0);
    for (int c = 0; c < 8; c++) begin
      readCh(c, d, dn, ov);
      check(dn == 0, "R1 reset done", dn, 0);
    end

    // R2 power-down blocks immediate and burst
    base = logCount;
    writeCfg(mkCfg(8'hff, 0, 0, 0, 1, 0));
    waitCycles(30);
    writeCfg(mkCfg(8'hff, 0, 1, 0, 0, 0));
    waitCycles(30);
    check(logCount == base, "R2 no start when powered down", logCount - base, 0);

    // R3 single immediate conversion, no re-arm
    writeCfg(mkCfg(0, 0, 0, 1, 0, 0));
    base = logCount;
    writeCfg(mkCfg(8'b1010_0100, 0, 0, 1, 1, 0));
    waitCycles(40);
    check(logCount == base + 1, "R3 exactly one conversion", logCount - base, 1);
    check(logChan[base] == 2, "R3 lowest selected channel", logChan[base], 2);
    check(logLen[base] == 11, "R4 full length", logLen[base], 11);
    readCh(2, d, dn, ov);
    check(d == int'(chanVal[2]), "R4 full result", d, int'(chanVal[2]));
    check(dn == 1 && ov == 0, "R10 done set no overrun", dn * 2 + ov, 2);
    readCh(2, d, dn, ov);
    check(dn == 0, "R10 read clears done", dn, 0);
    writeCfg(mkCfg(8'b1010_0100, 0, 0, 1, 1, 0));
    waitCycles(20);
    check(logCount == base + 2, "R3 re-arm on write", logCount - base, 2);

    // R3 empty mask
    base = logCount;
    writeCfg(mkCfg(0, 0, 0, 1, 1, 0));
    waitCycles(20);
    check(logCount == base, "R3 empty mask no start", logCount - base, 0);

    // R4 random speeds and masks
    for (int it = 0; it < 8; it++) begin
      randVals();
      sel = (it == 0) ? 7 : int'($urandom % 8);
      mask = int'($urandom % 255) + 1;
      ch = lowestBit(mask);
      base = logCount;
      writeCfg(mkCfg(mask, sel, 0, 1, 1, 0));
      waitCycles(18);
      check(logCount == base + 1 && logLen[base] == 11 - sel, "R4 length", logLen[base], 11 - sel);
      check(logChan[base] == ch, "R3 channel", logChan[base], ch);
      readCh(ch, d, dn, ov);
      check(d == int'(chanVal[ch] >> sel), "R4 shifted result", d, int'(chanVal[ch] >> sel));
    end

    // R5 burst scan order and restart at lowest
    for (int it = 0; it < 4; it++) begin
      mask = (it == 0) ? 8'b1000_0001 : (it == 1 ? 8'b1000_0001 : int'($urandom % 255) + 1);
      k = 0;
      for (int i = 0; i < 8; i++) if (mask[i]) begin list[k] = i; k++; end
      base = logCount;
      writeCfg(mkCfg(mask, 7, 1, 1, 0, 0));
      waitCount(base + 2 * k + 1);
      writeCfg(mkCfg(mask, 7, 0, 1, 0, 0));
      waitCycles(15);
      for (int i = 0; i < 2 * k + 1; i++)
        check(logChan[base + i] == list[i % k], "R5 scan order", logChan[base + i], list[i % k]);
    end

    // R7 stop burst mid conversion
    writeCfg(mkCfg(8'b0001_1000, 0, 1, 1, 0, 0));
    for (int i = 0; i < 200 && !(convActive && runLen == 3); i++) @(negedge clk);
    base = logCount;
    writeCfg(mkCfg(8'b0001_1000, 0, 0, 1, 0, 0));
    waitCycles(40);
    check(logCount == base + 1, "R7 only the running conversion finishes", logCount - base, 1);
    check(logLen[base] == 11, "R7 completed length", logLen[base], 11);

    // R11 config write mid conversion keeps channel and length
    base = logCount;
    writeCfg(mkCfg(8'b0100_0000, 0, 0, 1, 1, 0));
    waitCycles(3);
    writeCfg(mkCfg(8'b0000_0010, 7, 0, 1, 0, 0));
    waitCycles(20);
    check(logCount == base + 1 && logChan[base] == 6, "R11 channel held", logChan[base], 6);
    check(logLen[base] == 11, "R11 length held", logLen[base], 11);

    // R6 burst with nonzero start mode
    base = logCount;
    writeCfg(mkCfg(8'hff, 7, 1, 1, 1, 0));
    waitCycles(30);
    check(logCount == base, "R6 burst needs mode 0", logCount - base, 0);

    // R8 / R9 external triggers
    for (mode = 2; mode <= 6; mode++) begin
      fall = int'($urandom % 2);
      idx = mode - 2;
      other = (idx + 1) % 5;
      mask = int'($urandom % 255) + 1;
      writeCfg(mkCfg(0, 0, 0, 1, 0, 0));
      @(negedge clk);
      extTrig = (fall != 0) ? 5'h1f : 5'h00;
      waitCycles(5);
      base = logCount;
      writeCfg(mkCfg(mask, 0, 0, 1, mode, fall));
      waitCycles(3);
      @(negedge clk);
      extTrig[other] = ~extTrig[other];
      waitCycles(8);
      check(logCount == base && !convActive, "R8 other trigger ignored", logCount - base, 0);
      @(negedge clk);
      extTrig[idx] = ~extTrig[idx];
      @(posedge clk); @(posedge clk); #1;
      check(convActive == 1'b0, "R8 not before third edge", int'(convActive), 0);
      @(posedge clk); #1;
      check(convActive == 1'b1, "R8 start on third edge", int'(convActive), 1);
      check(int'(convChan) == lowestBit(mask), "R8 channel", int'(convChan), lowestBit(mask));
      @(negedge clk);
      extTrig[idx] = ~extTrig[idx];
      waitCycles(2);
      extTrig[idx] = ~extTrig[idx];
      waitCycles(25);
      check(logCount == base + 1, "R9 edges during conversion dropped", logCount - base, 1);
    end

    // R9 modes 7 and 0 never start
    for (int m = 0; m < 2; m++) begin
      base = logCount;
      writeCfg(mkCfg(8'hff, 0, 0, 1, m == 0 ? 7 : 0, 0));
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        extTrig = ~extTrig;
        waitCycles(5);
      end
      check(logCount == base, "R9 mode without start", logCount - base, 0);
    end

    // R10 overrun
    randVals();
    base = logCount;
    writeCfg(mkCfg(8'b0010_0000, 7, 1, 1, 0, 0));
    waitCount(base + 3);
    writeCfg(mkCfg(8'b0010_0000, 7, 0, 1, 0, 0));
    waitCycles(15);
    readCh(5, d, dn, ov);
    check(dn == 1 && ov == 1, "R10 overrun set", dn * 2 + ov, 3);
    check(d == int'(chanVal[5] >> 7), "R10 latest data", d, int'(chanVal[5] >> 7));
    readCh(5, d, dn, ov);
    check(dn == 0 && ov == 0, "R10 read clears both", dn * 2 + ov, 0);
    writeCfg(mkCfg(8'b0010_0000, 2, 0, 1, 1, 0));
    waitCycles(15);
    readCh(5, d, dn, ov);
    check(dn == 1 && ov == 0, "R10 fresh capture no overrun", dn * 2 + ov, 2);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule